// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block keeps a small set of recent page translations. Each translation maps a virtual page number to a physical frame number. Every entry also carries the identifier of the process that owns it, so entries from several address spaces can stay in the cache together and a context switch needs no flush. A lookup compares the requested page and the current process identifier against every entry at once. On a hit, the frame number and the read and write permissions come back combinationally in the same cycle.

On a miss, the block starts a refill handshake with an external table walker. The requester holds its request until a response appears. If the walker returns a valid mapping, the block installs it and completes the request in the cycle the walker answers, so the requester sees no fault. If the walker reports that no mapping exists, the block signals a page fault and stores nothing. Software-directed invalidation can clear every entry, every entry of one process, or the entry for one page of one process. Each of these completes in one cycle.

Top module: `pid_tlb`

## Requirements
- R1: When idle, a lookup whose page number and process identifier both equal those of a valid entry drives resp_valid high in the same cycle, with that entry's frame and permissions and resp_fault low.
- R2: An entry whose page number matches but whose process identifier differs does not hit. The lookup is treated as a miss.
- R3: A missing lookup raises walk_req_valid from the next cycle on, with walk_vpn and walk_pid holding the missed page and process. These stay stable until the cycle the walker answers with walk_rsp_valid.
- R4: When the walker answers with walk_rsp_ok high, resp_valid rises in that cycle with the walker's frame and permissions and resp_fault low. The mapping is installed, so a repeat of the same lookup hits without a walk.
- R5: When the walker answers with walk_rsp_ok low, resp_valid and resp_fault rise in that cycle and nothing is installed. A repeat of the lookup misses again.
- R6: inv_mode 2'b00 with inv_valid clears every entry in one cycle. inv_mode 2'b11 changes nothing.
- R7: inv_mode 2'b01 with inv_valid clears, in one cycle, exactly the entries whose process identifier equals inv_pid.
- R8: inv_mode 2'b10 with inv_valid clears only the entry whose page equals inv_vpn and whose process equals inv_pid.
- R9: A lookup in the same cycle as an invalidation sees the entries as they are after that invalidation. A refill answered in the same cycle as an invalidation still installs its entry.
- R10: A refill goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry named by a rotating pointer. The pointer starts at 0 after reset and moves one place on each such replacement.
- R11: During and right after reset, no entry is valid, walk_req_valid is low and no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request, held until resp_valid |
| req_vpn | input | 20 | Virtual page number to translate |
| req_pid | input | 8 | Process identifier of the request |
| resp_valid | output | 1 | Lookup completes this cycle |
| resp_frame | output | 20 | Physical frame number |
| resp_rd | output | 1 | Read permission |
| resp_wr | output | 1 | Write permission |
| resp_fault | output | 1 | Page fault, no mapping exists |
| walk_req_valid | output | 1 | Refill request to the walker |
| walk_vpn | output | 20 | Page to be walked |
| walk_pid | output | 8 | Process of the page to be walked |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_ok | input | 1 | Walker found a valid mapping |
| walk_rsp_frame | input | 20 | Frame returned by the walker |
| walk_rsp_rd | input | 1 | Read permission returned by the walker |
| walk_rsp_wr | input | 1 | Write permission returned by the walker |
| inv_valid | input | 1 | Invalidation command |
| inv_mode | input | 2 | 00 all, 01 by process, 10 one page, 11 none |
| inv_vpn | input | 20 | Page for single-page invalidation |
| inv_pid | input | 8 | Process for process or page invalidation |

## Verification
Invalidation can coincide with a lookup, and it can also coincide with a refill answer. The bench drives a page invalidation in the same cycle as a lookup of that very page, and expects a miss rather than a stale hit. It also issues a process-wide invalidation while a walk is outstanding, and checks that the refilled entry is still installed and that the other process's entries are gone. Both cases are judged every cycle against a behavioural model that applies the invalidation first and the lookup or install after it.

// File: rtl/pid_tlb_pkg.sv
// Shared types for the process-tagged translation cache.
// Assumes: invalidation codes are fixed two-bit values.
package pid_tlb_pkg;

    typedef enum logic [1:0] {
        INV_ALL  = 2'b00,
        INV_PID  = 2'b01,
        INV_PAGE = 2'b10,
        INV_NONE = 2'b11
    } inv_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

endpackage

// File: rtl/pid_tlb_array.sv
// Entry store with parallel tag compare and same-cycle invalidation.
// Assumes: at most one entry matches any page/process pair; invalidation
// applies before the lookup and before a write in the same cycle.
module pid_tlb_array
    import pid_tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int PFN_W = 20,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             inv_valid,
    input  inv_mode_e        inv_mode,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [PID_W-1:0] inv_pid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             wr_rd,
    input  logic             wr_wr,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    output logic             hit_rd,
    output logic             hit_wr,
    output logic [N-1:0]     live,
    output logic [N-1:0]     valid_o
);

    logic [N-1:0]     valid_q;
    logic [VPN_W-1:0] vpn_q [N];
    logic [PID_W-1:0] pid_q [N];
    logic [PFN_W-1:0] pfn_q [N];
    logic [N-1:0]     rd_q;
    logic [N-1:0]     wr_q;
    logic [N-1:0]     kill;
    logic [N-1:0]     match;
    logic [N-1:0]     sel;

    assign valid_o = valid_q;

    for (genvar i = 0; i < N; i++) begin : g_ent
        // Decide whether this entry is removed by the current command.
        always_comb begin
            kill[i] = 1'b0;
            if (inv_valid) begin
                unique case (inv_mode)
                    INV_ALL:  kill[i] = 1'b1;
                    INV_PID:  kill[i] = (pid_q[i] == inv_pid);
                    INV_PAGE: kill[i] = (pid_q[i] == inv_pid) && (vpn_q[i] == inv_vpn);
                    default:  kill[i] = 1'b0;
                endcase
            end
        end

        assign live[i]  = valid_q[i] & ~kill[i];
        assign match[i] = live[i] && (vpn_q[i] == lk_vpn) && (pid_q[i] == lk_pid);
        assign sel[i]   = wr_en && (wr_idx == IDX_W'(i));

        // Valid bit: survives invalidation or is set by an install.
        always_ff @(posedge clk) begin
            if (!rst_n) valid_q[i] <= 1'b0;
            else        valid_q[i] <= live[i] | sel[i];
        end

        // Payload written on install only.
        always_ff @(posedge clk) begin
            if (sel[i]) begin
                vpn_q[i] <= wr_vpn;
                pid_q[i] <= wr_pid;
                pfn_q[i] <= wr_pfn;
                rd_q[i]  <= wr_rd;
                wr_q[i]  <= wr_wr;
            end
        end
    end

    // OR-merge the single matching entry onto the hit outputs.
    always_comb begin
        hit     = 1'b0;
        hit_pfn = '0;
        hit_rd  = 1'b0;
        hit_wr  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_pfn = hit_pfn | pfn_q[i];
                hit_rd  = hit_rd | rd_q[i];
                hit_wr  = hit_wr | wr_q[i];
            end
        end
    end

endmodule

// File: rtl/pid_tlb_victim.sv
// Refill slot choice: lowest free entry, else a rotating pointer.
// Assumes: live reflects the entries after this cycle's invalidation.
module pid_tlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     live,
    input  logic             install,
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    // Priority search for the lowest-numbered free entry.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!live[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign victim = free_found ? free_idx : rr_q;

    // Rotating pointer moves only when a full cache is refilled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (install && !free_found) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/pid_tlb_ctrl.sv
// Lookup/refill sequencer: answers hits, runs the walker handshake on a miss.
// Assumes: the requester holds req_valid and its operands until resp_valid.
module pid_tlb_ctrl
    import pid_tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PID_W-1:0] req_pid,
    input  logic             hit,
    input  logic [PFN_W-1:0] hit_pfn,
    input  logic             hit_rd,
    input  logic             hit_wr,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_ok,
    input  logic [PFN_W-1:0] walk_rsp_frame,
    input  logic             walk_rsp_rd,
    input  logic             walk_rsp_wr,
    output logic             resp_valid,
    output logic [PFN_W-1:0] resp_frame,
    output logic             resp_rd,
    output logic             resp_wr,
    output logic             resp_fault,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_vpn,
    output logic [PID_W-1:0] walk_pid,
    output logic             install
);

    walk_state_e state_q;
    logic        idle_hit;
    logic        walk_done;

    assign idle_hit       = (state_q == ST_IDLE) && req_valid && hit;
    assign walk_done      = (state_q == ST_WALK) && walk_rsp_valid;
    assign walk_req_valid = (state_q == ST_WALK);
    assign install        = walk_done && walk_rsp_ok;

    // Response comes from the hit path when idle, else from the walker.
    always_comb begin
        resp_valid = idle_hit | walk_done;
        resp_fault = walk_done && !walk_rsp_ok;
        if (state_q == ST_IDLE) begin
            resp_frame = hit_pfn;
            resp_rd    = hit_rd;
            resp_wr    = hit_wr;
        end else begin
            resp_frame = walk_rsp_frame;
            resp_rd    = walk_rsp_rd;
            resp_wr    = walk_rsp_wr;
        end
    end

    // State: enter walk on an idle miss, leave when the walker answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (state_q == ST_IDLE) begin
            if (req_valid && !hit) state_q <= ST_WALK;
        end else if (walk_rsp_valid) begin
            state_q <= ST_IDLE;
        end
    end

    // Capture the missed page and process for the walker and the install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_vpn <= '0;
            walk_pid <= '0;
        end else if (state_q == ST_IDLE && req_valid && !hit) begin
            walk_vpn <= req_vpn;
            walk_pid <= req_pid;
        end
    end

endmodule

// File: rtl/pid_tlb.sv
// Process-tagged, fully associative translation cache with hardware refill.
// Assumes: one outstanding lookup; the walker answers on walk_req_valid.
module pid_tlb
    import pid_tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PID_W-1:0] req_pid,
    output logic             resp_valid,
    output logic [PFN_W-1:0] resp_frame,
    output logic             resp_rd,
    output logic             resp_wr,
    output logic             resp_fault,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_vpn,
    output logic [PID_W-1:0] walk_pid,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_ok,
    input  logic [PFN_W-1:0] walk_rsp_frame,
    input  logic             walk_rsp_rd,
    input  logic             walk_rsp_wr,
    input  logic             inv_valid,
    input  logic [1:0]       inv_mode,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [PID_W-1:0] inv_pid
);

    localparam int IDX_W = $clog2(N);

    logic             hit;
    logic [PFN_W-1:0] hit_pfn;
    logic             hit_rd;
    logic             hit_wr;
    logic [N-1:0]     live;
    logic [N-1:0]     ent_valid;
    logic             do_install;
    logic [IDX_W-1:0] victim;

    pid_tlb_array #(
        .N(N), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (req_vpn),
        .lk_pid    (req_pid),
        .inv_valid (inv_valid),
        .inv_mode  (inv_mode_e'(inv_mode)),
        .inv_vpn   (inv_vpn),
        .inv_pid   (inv_pid),
        .wr_en     (do_install),
        .wr_idx    (victim),
        .wr_vpn    (walk_vpn),
        .wr_pid    (walk_pid),
        .wr_pfn    (walk_rsp_frame),
        .wr_rd     (walk_rsp_rd),
        .wr_wr     (walk_rsp_wr),
        .hit       (hit),
        .hit_pfn   (hit_pfn),
        .hit_rd    (hit_rd),
        .hit_wr    (hit_wr),
        .live      (live),
        .valid_o   (ent_valid)
    );

    pid_tlb_victim #(.N(N), .IDX_W(IDX_W)) u_vic (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (live),
        .install (do_install),
        .victim  (victim)
    );

    pid_tlb_ctrl #(.VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_vpn        (req_vpn),
        .req_pid        (req_pid),
        .hit            (hit),
        .hit_pfn        (hit_pfn),
        .hit_rd         (hit_rd),
        .hit_wr         (hit_wr),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_ok    (walk_rsp_ok),
        .walk_rsp_frame (walk_rsp_frame),
        .walk_rsp_rd    (walk_rsp_rd),
        .walk_rsp_wr    (walk_rsp_wr),
        .resp_valid     (resp_valid),
        .resp_frame     (resp_frame),
        .resp_rd        (resp_rd),
        .resp_wr        (resp_wr),
        .resp_fault     (resp_fault),
        .walk_req_valid (walk_req_valid),
        .walk_vpn       (walk_vpn),
        .walk_pid       (walk_pid),
        .install        (do_install)
    );

endmodule

// File: rtl/pid_tlb_chk.sv
// Protocol and state checks for pid_tlb, attached by bind.
// Assumes: ent_valid is the stored valid vector, do_install the write strobe.
module pid_tlb_chk #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int PFN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             resp_valid,
    input logic             resp_fault,
    input logic [PFN_W-1:0] resp_frame,
    input logic             walk_req_valid,
    input logic [VPN_W-1:0] walk_vpn,
    input logic [PID_W-1:0] walk_pid,
    input logic             walk_rsp_valid,
    input logic             walk_rsp_ok,
    input logic [PFN_W-1:0] walk_rsp_frame,
    input logic             inv_valid,
    input logic [1:0]       inv_mode,
    input logic [N-1:0]     ent_valid,
    input logic             do_install
);

    // R1
    hit_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !walk_req_valid |-> !resp_fault);

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid && !walk_rsp_valid |=>
            walk_req_valid && $stable(walk_vpn) && $stable(walk_pid));

    // R4
    refill_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid && walk_rsp_valid && walk_rsp_ok |->
            resp_valid && !resp_fault && resp_frame == walk_rsp_frame);

    // R5
    refill_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid && walk_rsp_valid && !walk_rsp_ok |->
            resp_valid && resp_fault && !do_install);

    // R6
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && inv_mode == 2'b00 && !do_install |=> ent_valid == '0);

    // R10
    fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_install && !inv_valid && $countones(ent_valid) < N |=>
            $countones(ent_valid) == $past($countones(ent_valid)) + 1);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ent_valid == '0 && !walk_req_valid);

endmodule

bind pid_tlb pid_tlb_chk #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .resp_valid     (resp_valid),
    .resp_fault     (resp_fault),
    .resp_frame     (resp_frame),
    .walk_req_valid (walk_req_valid),
    .walk_vpn       (walk_vpn),
    .walk_pid       (walk_pid),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_rsp_ok    (walk_rsp_ok),
    .walk_rsp_frame (walk_rsp_frame),
    .inv_valid      (inv_valid),
    .inv_mode       (inv_mode),
    .ent_valid      (ent_valid),
    .do_install     (do_install)
);

// File: tb/pid_tlb_tb.sv
`timescale 1ns/1ps
// Bench: behavioural cache model compared with the design on every clock.
module pid_tlb_tb;

    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_vpn = '0;
    logic [7:0]  req_pid = '0;
    logic        resp_valid, resp_rd, resp_wr, resp_fault;
    logic [19:0] resp_frame;
    logic        walk_req_valid;
    logic [19:0] walk_vpn;
    logic [7:0]  walk_pid;
    logic        walk_rsp_valid = 1'b0, walk_rsp_ok = 1'b0;
    logic [19:0] walk_rsp_frame = '0;
    logic        walk_rsp_rd = 1'b0, walk_rsp_wr = 1'b0;
    logic        inv_valid = 1'b0;
    logic [1:0]  inv_mode = 2'b11;
    logic [19:0] inv_vpn = '0;
    logic [7:0]  inv_pid = '0;

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R11";
    bit    last_resp;

    // Reference state
    bit        m_v   [NE];
    bit [19:0] m_vpn [NE];
    bit [7:0]  m_pid [NE];
    bit [19:0] m_pfn [NE];
    bit        m_rd  [NE];
    bit        m_wr  [NE];
    int        m_rr = 0;
    bit        m_walk = 0;
    bit [19:0] m_wvpn = '0;
    bit [7:0]  m_wpid = '0;

    pid_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_pid(req_pid),
        .resp_valid(resp_valid), .resp_frame(resp_frame), .resp_rd(resp_rd),
        .resp_wr(resp_wr), .resp_fault(resp_fault),
        .walk_req_valid(walk_req_valid), .walk_vpn(walk_vpn), .walk_pid(walk_pid),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ok(walk_rsp_ok),
        .walk_rsp_frame(walk_rsp_frame), .walk_rsp_rd(walk_rsp_rd),
        .walk_rsp_wr(walk_rsp_wr),
        .inv_valid(inv_valid), .inv_mode(inv_mode), .inv_vpn(inv_vpn), .inv_pid(inv_pid)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit [19:0] mkframe(input bit [19:0] v, input bit [7:0] p);
        return v ^ {p, 12'h5A3};
    endfunction

    // One clock: compare outputs with the model, then advance the model.
    task automatic cyc();
        bit live [NE];
        bit hit;
        int hidx;
        int vic;
        logic [63:0] act, exp;
        #1;
        hit = 0; hidx = 0;
        for (int i = 0; i < NE; i++) begin
            bit kill;
            kill = 0;
            if (inv_valid) begin
                if (inv_mode == 2'b00) kill = 1;
                else if (inv_mode == 2'b01) kill = (m_pid[i] == inv_pid);
                else if (inv_mode == 2'b10) kill = (m_pid[i] == inv_pid) && (m_vpn[i] == inv_vpn);
            end
            live[i] = m_v[i] && !kill;
            if (live[i] && m_vpn[i] == req_vpn && m_pid[i] == req_pid) begin
                hit = 1; hidx = i;
            end
        end
        exp = '0;
        if (!m_walk && req_valid && hit)
            exp[63:40] = {1'b1, 1'b0, m_pfn[hidx], m_rd[hidx], m_wr[hidx]};
        else if (m_walk && walk_rsp_valid)
            exp[63:40] = walk_rsp_ok ? {1'b1, 1'b0, walk_rsp_frame, walk_rsp_rd, walk_rsp_wr}
                                     : {1'b1, 1'b1, 22'h0};
        if (m_walk) exp[39:11] = {1'b1, m_wvpn, m_wpid};
        act = '0;
        if (resp_valid)
            act[63:40] = resp_fault ? {1'b1, 1'b1, 22'h0}
                                    : {1'b1, 1'b0, resp_frame, resp_rd, resp_wr};
        if (walk_req_valid) act[39:11] = {1'b1, walk_vpn, walk_pid};
        last_resp = resp_valid;
        check(act === exp, cur_tag, act, exp);
        // advance
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) m_v[i] = 0;
            m_rr = 0; m_walk = 0;
        end else begin
            for (int i = 0; i < NE; i++) m_v[i] = live[i];
            if (!m_walk) begin
                if (req_valid && !hit) begin
                    m_walk = 1; m_wvpn = req_vpn; m_wpid = req_pid;
                end
            end else if (walk_rsp_valid) begin
                m_walk = 0;
                if (walk_rsp_ok) begin
                    vic = -1;
                    for (int i = NE - 1; i >= 0; i--) if (!live[i]) vic = i;
                    if (vic < 0) begin
                        vic = m_rr;
                        m_rr = (m_rr + 1) % NE;
                    end
                    m_v[vic] = 1; m_vpn[vic] = m_wvpn; m_pid[vic] = m_wpid;
                    m_pfn[vic] = walk_rsp_frame; m_rd[vic] = walk_rsp_rd; m_wr[vic] = walk_rsp_wr;
                end
            end
        end
        @(negedge clk);
    endtask

    // Full lookup; a miss is answered by the walker after one wait cycle.
    task automatic access(input bit [19:0] v, input bit [7:0] p, input bit ok,
                          input bit exp_hit, input string tag);
        cur_tag = tag;
        req_valid = 1; req_vpn = v; req_pid = p;
        cyc();
        check(last_resp == exp_hit, tag, 64'(last_resp), 64'(exp_hit));
        if (!last_resp) begin
            cyc();
            walk_rsp_valid = 1; walk_rsp_ok = ok;
            walk_rsp_frame = mkframe(v, p); walk_rsp_rd = ~v[0]; walk_rsp_wr = v[1];
            cyc();
            walk_rsp_valid = 0; walk_rsp_ok = 0;
        end
        req_valid = 0;
    endtask

    task automatic invalidate(input bit [1:0] mode, input bit [19:0] v, input bit [7:0] p,
                              input string tag);
        cur_tag = tag;
        inv_valid = 1; inv_mode = mode; inv_vpn = v; inv_pid = p;
        cyc();
        inv_valid = 0; inv_mode = 2'b11;
    endtask

    initial begin
        @(negedge clk);
        cur_tag = "R11";
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        check(walk_req_valid == 0, "R11", 64'(walk_req_valid), 64'(0));

        // R3 R4 R1: miss, refill, then hit
        access(20'h12345, 8'd3, 1, 0, "R4");
        access(20'h12345, 8'd3, 1, 1, "R1");
        // R2: same page, other process
        access(20'h12345, 8'd4, 1, 0, "R2");
        access(20'h12345, 8'd4, 1, 1, "R2");
        // R5: fault installs nothing
        access(20'h00777, 8'd3, 0, 0, "R5");
        access(20'h00777, 8'd3, 0, 0, "R5");
        access(20'h12345, 8'd3, 1, 1, "R5");

        // R8: single page of one process
        invalidate(2'b10, 20'h12345, 8'd3, "R8");
        access(20'h12345, 8'd4, 1, 1, "R8");
        access(20'h12345, 8'd3, 1, 0, "R8");

        // R7: by process
        access(20'h00050, 8'd5, 1, 0, "R7");
        access(20'h00051, 8'd5, 1, 0, "R7");
        access(20'h00060, 8'd6, 1, 0, "R7");
        invalidate(2'b01, 20'h0, 8'd5, "R7");
        access(20'h00060, 8'd6, 1, 1, "R7");
        access(20'h00050, 8'd5, 1, 0, "R7");
        access(20'h00051, 8'd5, 1, 0, "R7");

        // R6: no-op code then flush
        invalidate(2'b11, 20'h00060, 8'd6, "R6");
        access(20'h00060, 8'd6, 1, 1, "R6");
        invalidate(2'b00, 20'h0, 8'd0, "R6");
        access(20'h00060, 8'd6, 1, 0, "R6");
        access(20'h12345, 8'd4, 1, 0, "R6");

        // R9: lookup in the same cycle as invalidation of that page
        cur_tag = "R9";
        inv_valid = 1; inv_mode = 2'b10; inv_vpn = 20'h00060; inv_pid = 8'd6;
        req_valid = 1; req_vpn = 20'h00060; req_pid = 8'd6;
        cyc();
        check(last_resp == 0, "R9", 64'(last_resp), 64'(0));
        inv_valid = 0; inv_mode = 2'b11;
        cyc();
        // R9: process-wide invalidation coinciding with the refill answer
        inv_valid = 1; inv_mode = 2'b01; inv_pid = 8'd4;
        walk_rsp_valid = 1; walk_rsp_ok = 1; walk_rsp_frame = mkframe(20'h00060, 8'd6);
        walk_rsp_rd = 1; walk_rsp_wr = 0;
        cyc();
        inv_valid = 0; inv_mode = 2'b11; walk_rsp_valid = 0; walk_rsp_ok = 0; req_valid = 0;
        access(20'h00060, 8'd6, 1, 1, "R9");
        access(20'h12345, 8'd4, 1, 0, "R9");

        // R10: fill, then rotating replacement and free-slot reuse
        invalidate(2'b00, 20'h0, 8'd0, "R10");
        for (int k = 0; k < NE; k++) access(20'h00100 + 20'(k), 8'd9, 1, 0, "R10");
        access(20'h00200, 8'd9, 1, 0, "R10");
        access(20'h00101, 8'd9, 1, 1, "R10");
        access(20'h00100, 8'd9, 1, 0, "R10");
        access(20'h00101, 8'd9, 1, 0, "R10");
        invalidate(2'b10, 20'h00105, 8'd9, "R10");
        access(20'h00300, 8'd9, 1, 0, "R10");
        access(20'h00104, 8'd9, 1, 1, "R10");
        access(20'h00106, 8'd9, 1, 1, "R10");
        access(20'h00300, 8'd9, 1, 1, "R10");
        access(20'h00200, 8'd9, 1, 1, "R10");

        // R3: long walker delay keeps the request stable
        cur_tag = "R3";
        req_valid = 1; req_vpn = 20'hABCDE; req_pid = 8'd7;
        repeat (5) cyc();
        walk_rsp_valid = 1; walk_rsp_ok = 1; walk_rsp_frame = 20'h0F00F;
        cyc();
        walk_rsp_valid = 0; walk_rsp_ok = 0; req_valid = 0;
        access(20'hABCDE, 8'd7, 1, 1, "R3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule